// File: doc/BRIEF.md
# ADC Result FIFO with Threshold Interrupt

This block collects conversion results from a multi-channel ADC sequencer into a small circular store. A CPU or DMA engine drains the store through one 32-bit read port. Each entry keeps a 12-bit result together with the channel number that produced it. The read word places the result in its low bits and the status in its upper half. A read of an empty store is marked in-band, so software cannot mistake it for a genuine zero conversion.

A signed down-counting threshold counter drives an interrupt flag that does not depend on the end-of-sequence flag. Software loads the counter with a threshold, which is typically half the depth. Every stored result counts it down and every successful read counts it back up. The flag sets when stored results bring the counter to zero. A separate group-end flag sets whenever the sequencer marks the last channel of a sequence. A third flag, for overrun, is sticky and records that a result was lost. All three flags clear when software writes a 1 to them.

Top module: `adc_result_fifo`

## Requirements
- R1: The store holds up to 16 results, and reads return them in the order they were written.
- R2: A read of a non-empty store returns the result in bits 11:0 and the channel id in bits 20:16. All other bits, including bit 31, are zero.
- R3: While the store is empty, rd_data is 0x8000_0000. A read in that state does not consume anything, so the next result written is the next one read.
- R4: A write while the store is full and no read is accepted in the same cycle is dropped and sets the overrun flag (flags bit 1). If a read is accepted in the same cycle, the write is stored. The overrun flag stays set until it is cleared.
- R5: thr_cnt resets to 8. When thr_load is high, thr_cnt takes thr_value, and a load overrides everything else. Otherwise each stored result subtracts 1 and each accepted read adds 1. If both happen in the same cycle, thr_cnt is unchanged.
- R6: thr_cnt is a 9-bit two's-complement value that wraps: a store at -256 (0x100) gives +255 (0x0FF).
- R7: The threshold flag (flags bit 0) sets in the cycle after a store moves thr_cnt from 1 to 0. This happens whether or not the interrupt is enabled.
- R8: The group-end flag (flags bit 3) sets in the cycle after any write with wr_last high, whether or not that result was stored.
- R9: When flg_clr_we is high, every flag bit that is 1 in flg_clr_mask is cleared. A flag being set in that same cycle wins over its clear. Flags bit 2 always reads 0.
- R10: thr_irq is high exactly when the threshold flag is set and thr_irq_en is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | A conversion result is presented |
| wr_result | input | 12 | Conversion result |
| wr_chan | input | 5 | Channel id of the result |
| wr_last | input | 1 | Result is the last of its sequence |
| rd_en | input | 1 | Read strobe; consumes the head entry |
| rd_data | output | 32 | Head entry with status; valid in the cycle of rd_en |
| thr_load | input | 1 | Load the threshold counter |
| thr_value | input | 9 | Value loaded into the threshold counter |
| thr_cnt | output | 9 | Threshold counter, two's complement |
| flg_clr_we | input | 1 | Apply the clear mask |
| flg_clr_mask | input | 4 | Write-1-to-clear mask |
| flags | output | 4 | bit0 threshold, bit1 overrun, bit2 zero, bit3 group end |
| thr_irq_en | input | 1 | Threshold interrupt enable |
| thr_irq | output | 1 | Threshold interrupt |

## Verification
The wrap of the threshold counter cannot be reached by traffic alone. Because the store holds only 16 entries, the counter never drifts more than 16 away from its loaded value. The stimulus therefore loads -256 directly into an empty store and then writes one result to force the wrap to +255. Every threshold from 1 to 16 is swept, toggling the interrupt enable between runs, and the bench confirms that the flag rises on exactly the T-th store. A full store is also hit with a read and a write in the same cycle, and another write in the following cycle, to show which writes are kept and which set overrun.

// File: rtl/adcfifo_pkg.sv
package adcfifo_pkg;
   // Read-word layout
   localparam int RD_W      = 32;
   localparam int EMPTY_BIT = 31;
   localparam int CH_LSB    = 16;
   // Flag register layout
   localparam int FLG_W     = 4;
   localparam int FLG_THR   = 0;
   localparam int FLG_OVR   = 1;
   localparam int FLG_RSV   = 2;
   localparam int FLG_END   = 3;
endpackage

// File: rtl/adcfifo_mem.sv
module adcfifo_mem #(
   parameter int DEPTH = 16,
   parameter int W     = 17,
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic         pop,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] rdata,
   output logic         full,
   output logic         empty
);
   logic [W-1:0]  store [DEPTH];
   logic [AW-1:0] wp, rp, wp_nx, rp_nx;
   logic [AW:0]   lvl;

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("adcfifo_mem: DEPTH must be at least 2");
      end
      if ((1 << AW) == DEPTH) begin : g_pow2
         assign wp_nx = wp + 1'b1;
         assign rp_nx = rp + 1'b1;
      end else begin : g_mod
         assign wp_nx = (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
         assign rp_nx = (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         lvl <= '0;
      end else begin
         if (push) wp <= wp_nx;
         if (pop)  rp <= rp_nx;
         case ({push, pop})
            2'b10:   lvl <= lvl + 1'b1;
            2'b01:   lvl <= lvl - 1'b1;
            default: lvl <= lvl;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (push) store[wp] <= wdata;
   end

   assign rdata = store[rp];
   assign full  = (lvl == (AW+1)'(DEPTH));
   assign empty = (lvl == '0);
endmodule

// File: rtl/adcfifo_thr.sv
module adcfifo_thr #(
   parameter int CNT_W = 9,
   parameter int INIT  = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             dec,
   input  logic             inc,
   output logic [CNT_W-1:0] cnt,
   output logic             hit
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   // Two's-complement wrap falls out of plain modular arithmetic.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= CNT_W'(INIT);
      else if (load)           cnt <= load_val;
      else if (dec && !inc)    cnt <= cnt - 1'b1;
      else if (inc && !dec)    cnt <= cnt + 1'b1;
   end

   assign hit = !load && dec && !inc && (cnt == ONE);
endmodule

// File: rtl/adc_result_fifo.sv
module adc_result_fifo
   import adcfifo_pkg::*;
#(
   parameter int DEPTH    = 16,
   parameter int DATA_W   = 12,
   parameter int CH_W     = 5,
   parameter int CNT_W    = 9,
   parameter int THR_INIT = DEPTH / 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic [DATA_W-1:0] wr_result,
   input  logic [CH_W-1:0]   wr_chan,
   input  logic              wr_last,
   input  logic              rd_en,
   output logic [RD_W-1:0]   rd_data,
   input  logic              thr_load,
   input  logic [CNT_W-1:0]  thr_value,
   output logic [CNT_W-1:0]  thr_cnt,
   input  logic              flg_clr_we,
   input  logic [FLG_W-1:0]  flg_clr_mask,
   output logic [FLG_W-1:0]  flags,
   input  logic              thr_irq_en,
   output logic              thr_irq
);
   localparam int ENT_W = DATA_W + CH_W;

   generate
      if (DATA_W > CH_LSB) begin : g_bad_data
         $error("adc_result_fifo: DATA_W must fit below the status half");
      end
      if (CH_LSB + CH_W > EMPTY_BIT) begin : g_bad_chan
         $error("adc_result_fifo: CH_W collides with the empty bit");
      end
      if (CNT_W < $clog2(DEPTH) + 2) begin : g_bad_cnt
         $error("adc_result_fifo: CNT_W too narrow for DEPTH");
      end
   endgenerate

   logic             fifo_full, fifo_empty;
   logic             pop_ok, push_ok, ovr_evt, thr_hit;
   logic [ENT_W-1:0] head;
   logic [FLG_W-1:0] flg_q, flg_set, flg_clr;

   assign pop_ok  = rd_en && !fifo_empty;
   assign push_ok = wr_valid && (!fifo_full || pop_ok);
   assign ovr_evt = wr_valid && !push_ok;

   adcfifo_mem #(.DEPTH(DEPTH), .W(ENT_W)) u_mem (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push_ok),
      .pop   (pop_ok),
      .wdata ({wr_chan, wr_result}),
      .rdata (head),
      .full  (fifo_full),
      .empty (fifo_empty)
   );

   adcfifo_thr #(.CNT_W(CNT_W), .INIT(THR_INIT)) u_thr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (thr_load),
      .load_val (thr_value),
      .dec      (push_ok),
      .inc      (pop_ok),
      .cnt      (thr_cnt),
      .hit      (thr_hit)
   );

   always_comb begin
      rd_data = '0;
      if (fifo_empty) begin
         rd_data[EMPTY_BIT] = 1'b1;
      end else begin
         rd_data[DATA_W-1:0]       = head[DATA_W-1:0];
         rd_data[CH_LSB +: CH_W]   = head[ENT_W-1 -: CH_W];
      end
   end

   always_comb begin
      flg_set          = '0;
      flg_set[FLG_THR] = thr_hit;
      flg_set[FLG_OVR] = ovr_evt;
      flg_set[FLG_RSV] = 1'b0;
      flg_set[FLG_END] = wr_valid && wr_last;
      flg_clr          = flg_clr_we ? flg_clr_mask : '0;
      flg_clr[FLG_RSV] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flg_q <= '0;
      else        flg_q <= (flg_q & ~flg_clr) | flg_set;
   end

   assign flags   = flg_q;
   assign thr_irq = flg_q[FLG_THR] && thr_irq_en;
endmodule

// File: rtl/adcfifo_chk.sv
module adcfifo_chk #(
   parameter int CNT_W = 9
) (
   input logic             clk,
   input logic             rst_n,
   input logic [31:0]      rd_data,
   input logic [3:0]       flags,
   input logic [CNT_W-1:0] thr_cnt,
   input logic [CNT_W-1:0] thr_value,
   input logic             thr_load,
   input logic             thr_irq,
   input logic             thr_irq_en,
   input logic             push,
   input logic             pop,
   input logic             wr_valid,
   input logic             wr_last,
   input logic             clr_we,
   input logic [3:0]       clr_mask,
   input logic             empty
);
   // R3
   empty_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      empty |-> rd_data == 32'h8000_0000);
   // R2
   valid_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !empty |-> !rd_data[31]);
   // R5
   cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      thr_load |=> thr_cnt == $past(thr_value));
   // R5
   cnt_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!thr_load && push && !pop) |=> thr_cnt == CNT_W'($past(thr_cnt) - 1'b1));
   // R5
   cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!thr_load && push && pop) |=> $stable(thr_cnt));
   // R7
   thr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!thr_load && push && !pop && thr_cnt == CNT_W'(1)) |=> flags[0]);
   // R4
   ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[1] && !(clr_we && clr_mask[1])) |=> flags[1]);
   // R8
   end_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && wr_last) |=> flags[3]);
   // R9
   rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !flags[2]);
   // R10
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !thr_irq_en |-> !thr_irq);
endmodule

bind adc_result_fifo adcfifo_chk #(.CNT_W(CNT_W)) u_adcfifo_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .rd_data    (rd_data),
   .flags      (flags),
   .thr_cnt    (thr_cnt),
   .thr_value  (thr_value),
   .thr_load   (thr_load),
   .thr_irq    (thr_irq),
   .thr_irq_en (thr_irq_en),
   .push       (push_ok),
   .pop        (pop_ok),
   .wr_valid   (wr_valid),
   .wr_last    (wr_last),
   .clr_we     (flg_clr_we),
   .clr_mask   (flg_clr_mask),
   .empty      (fifo_empty)
);

// File: tb/test_adc_result_fifo.sv
`timescale 1ns/1ps
module test_adc_result_fifo;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_valid = 1'b0;
   logic [11:0] wr_result = '0;
   logic [4:0]  wr_chan = '0;
   logic        wr_last = 1'b0;
   logic        rd_en = 1'b0;
   logic [31:0] rd_data;
   logic        thr_load = 1'b0;
   logic [8:0]  thr_value = '0;
   logic [8:0]  thr_cnt;
   logic        flg_clr_we = 1'b0;
   logic [3:0]  flg_clr_mask = '0;
   logic [3:0]  flags;
   logic        thr_irq_en = 1'b0;
   logic        thr_irq;

   int checks = 0;
   int errors = 0;

   // Bench model of the queue, counter and flags
   logic [11:0] qd [16];
   logic [4:0]  qc [16];
   int          lvl = 0, rp = 0, wp = 0;
   logic [8:0]  m_cnt = 9'd8;
   logic [3:0]  m_flg = 4'h0;

   always #4 clk = ~clk;

   adc_result_fifo i_adc_result_fifo (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_result(wr_result),
      .wr_chan(wr_chan), .wr_last(wr_last), .rd_en(rd_en), .rd_data(rd_data),
      .thr_load(thr_load), .thr_value(thr_value), .thr_cnt(thr_cnt),
      .flg_clr_we(flg_clr_we), .flg_clr_mask(flg_clr_mask), .flags(flags),
      .thr_irq_en(thr_irq_en), .thr_irq(thr_irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic step(input bit wv, input logic [11:0] d, input logic [4:0] c,
                       input bit lst, input bit rd, input bit ld, input logic [8:0] lv,
                       input bit cw, input logic [3:0] cm);
      logic [31:0] exp_word;
      bit pop, acc, hit;
      @(negedge clk);
      wr_valid = wv; wr_result = d; wr_chan = c; wr_last = lst; rd_en = rd;
      thr_load = ld; thr_value = lv; flg_clr_we = cw; flg_clr_mask = cm;
      #1;
      exp_word = (lvl == 0) ? 32'h8000_0000 : {11'b0, qc[rp], 4'b0, qd[rp]};
      chk((lvl == 0) ? "R3 empty word" : "R1/R2 read word", rd_data, exp_word);
      pop = rd && (lvl > 0);
      acc = wv && ((lvl < 16) || pop);
      hit = !ld && acc && !pop && (m_cnt == 9'd1);
      if (pop) begin rp = (rp + 1) % 16; lvl--; end
      if (acc) begin qd[wp] = d; qc[wp] = c; wp = (wp + 1) % 16; lvl++; end
      if (ld) m_cnt = lv;
      else if (acc && !pop) m_cnt = m_cnt - 9'd1;
      else if (pop && !acc) m_cnt = m_cnt + 9'd1;
      m_flg = (m_flg & ~(cw ? cm : 4'h0)) | {wv && lst, 1'b0, wv && !acc, hit};
      @(posedge clk);
      #1;
      wr_valid = 0; rd_en = 0; thr_load = 0; flg_clr_we = 0; wr_last = 0;
      chk("R5/R6 counter", {23'b0, thr_cnt}, {23'b0, m_cnt});
      chk("R4/R7/R8/R9 flags", {28'b0, flags}, {28'b0, m_flg});
      chk("R10 irq", {31'b0, thr_irq}, {31'b0, m_flg[0] && thr_irq_en});
   endtask

   task automatic wr(input logic [11:0] d, input logic [4:0] c, input bit lst);
      step(1, d, c, lst, 0, 0, '0, 0, '0);
   endtask
   task automatic rd1();
      step(0, '0, '0, 0, 1, 0, '0, 0, '0);
   endtask
   task automatic ld(input logic [8:0] v);
      step(0, '0, '0, 0, 0, 1, v, 0, '0);
   endtask
   task automatic clr(input logic [3:0] m);
      step(0, '0, '0, 0, 0, 0, '0, 1, m);
   endtask
   task automatic drain();
      while (lvl > 0) rd1();
   endtask

   function automatic logic [4:0] chan_of(input int k);
      case (k % 4)
         0: return 5'd8;
         1: return 5'd9;
         2: return 5'd10;
         default: return 5'd13;
      endcase
   endfunction

   initial begin
      #(8 * 200000);
      errors++;
      checks++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      #2;
      // Reset state (R3, R5, R9, R10)
      chk("R3 reset word", rd_data, 32'h8000_0000);
      chk("R5 reset counter", {23'b0, thr_cnt}, 32'd8);
      chk("R9 reset flags", {28'b0, flags}, 32'h0);
      chk("R10 reset irq", {31'b0, thr_irq}, 32'h0);

      // Two four-channel groups reach the default threshold of 8 (R7, R8, R10)
      thr_irq_en = 1'b1;
      for (int k = 0; k < 8; k++) wr(12'(k * 37 + 100), chan_of(k), (k % 4) == 3);
      clr(4'h9);
      // Overfill: two results dropped (R4)
      for (int k = 8; k < 18; k++) wr(12'(k * 53 + 7), chan_of(k), 0);
      // Drain in order then read empty (R1, R2, R3)
      drain();
      rd1();
      rd1();
      // Empty read did not move the pointer (R3)
      wr(12'hABC, 5'd13, 0);
      rd1();
      // Clear overrun only (R9)
      clr(4'h2);
      // Full with simultaneous read and write, then a dropped write (R4)
      for (int k = 0; k < 16; k++) wr(12'(4095 - k), chan_of(k), 0);
      step(1, 12'h5A5, 5'd31, 0, 1, 0, '0, 0, '0);
      wr(12'h111, 5'd1, 0);
      drain();
      clr(4'hF);
      // Set wins over clear in the same cycle (R9, R8)
      step(1, 12'h0F0, 5'd9, 1, 0, 0, '0, 1, 4'h8);
      drain();
      clr(4'hF);
      // Counter wrap (R6) and restore by read
      ld(9'h100);
      wr(12'h001, 5'd8, 0);
      rd1();
      // Load wins over simultaneous write (R5)
      step(1, 12'h777, 5'd10, 0, 0, 1, 9'd3, 0, '0);
      drain();
      // Threshold sweep, every value 1..16, enable alternating (R7, R10)
      for (int t = 1; t <= 16; t++) begin
         thr_irq_en = (t % 2) == 0;
         clr(4'hF);
         ld(9'(t));
         for (int k = 0; k < t; k++) wr(12'(t * 100 + k), chan_of(k), (k % 4) == 3);
         drain();
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule